// File: doc/BRIEF.md
# Transceiver Channel Reset Sequencer

This block brings one multi-gigabit serial transceiver channel out of reset in a fixed order. At system reset it asserts every reset and power-down control of the channel. After a counted interval it releases power-down and the transmit PLL reset together. It then waits for the PLL lock indication. It does not release the transmit digital logic on the cycle lock is first seen. It releases it only after a programmable settling count. A transmitter whose digital reset is removed too early can lock up sending comma characters in place of user data, and this count prevents that.

The receiver is released next. The receiver analog reset waits for the calibration-busy indication to clear and then a short count. The receiver digital reset waits for the receive clock-recovery lock and then a longer count. A done flag is high whenever the channel is fully out of reset with all lock indications valid. A later loss of PLL lock sends the channel back to the wait-for-lock stage. A later loss of receive lock repeats only the last stage. All three status inputs pass through a synchronizer before the state machine uses them. The synchronizer has SYNC_STAGES flops, 2 by default.

Top module: `xrs_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `pwr_down_o`, `pll_rst_o`, `tx_dig_rst_o`, `rx_ana_rst_o` and `rx_dig_rst_o` are all 1 and `seq_done_o` is 0.
- R2: `pwr_down_o` and `pll_rst_o` always carry equal values. Both fall after exactly PD_CYCLES rising edges. The count starts with the first edge that samples `rst` low.
- R3: `tx_dig_rst_o` stays 1 for as long as `pll_lock_in` is low, however long that lasts.
- R4: Once `pll_lock_in` rises and stays high, `tx_dig_rst_o` falls after exactly SYNC_STAGES+1+TX_SETTLE rising edges. The count includes the first edge that samples the input high. If lock drops during the settling count, the count is discarded and restarts from the next rise.
- R5: `rx_ana_rst_o` stays 1 while `cal_busy_in` is high. After `tx_dig_rst_o` has fallen, a fall of `cal_busy_in` makes `rx_ana_rst_o` fall after exactly SYNC_STAGES+1+RX_ANA_CYCLES edges. If busy is already low, it falls RX_ANA_CYCLES+1 edges after `tx_dig_rst_o` falls.
- R6: `rx_dig_rst_o` stays 1 while `cdr_lock_in` is low. After `rx_ana_rst_o` has fallen, a rise of `cdr_lock_in` makes `rx_dig_rst_o` fall after exactly SYNC_STAGES+1+RX_DIG_CYCLES edges. If lock is already high, it falls RX_DIG_CYCLES+1 edges after `rx_ana_rst_o` falls.
- R7: `seq_done_o` rises on the same edge on which `rx_dig_rst_o` falls. It is high only while all five reset outputs are 0.
- R8: If `pll_lock_in` falls after `tx_dig_rst_o` has been released, `tx_dig_rst_o`, `rx_ana_rst_o` and `rx_dig_rst_o` return to 1 and `seq_done_o` goes to 0 exactly SYNC_STAGES+1 edges later. `pwr_down_o` and `pll_rst_o` stay 0. The sequence then resumes as in R4.
- R9: If `cdr_lock_in` falls while `seq_done_o` is 1, only `rx_dig_rst_o` returns to 1, exactly SYNC_STAGES+1 edges later. `tx_dig_rst_o` and `rx_ana_rst_o` stay 0. The R6 wait and count then repeat.
- R10: Outside reset, `rx_ana_rst_o` is never 0 while `tx_dig_rst_o` is 1, and `rx_dig_rst_o` is never 0 while `rx_ana_rst_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running control clock |
| rst | input | 1 | Synchronous active-high system reset |
| pll_lock_in | input | 1 | Transmit PLL lock status, asynchronous |
| cal_busy_in | input | 1 | Receiver calibration busy status, asynchronous |
| cdr_lock_in | input | 1 | Receive clock-recovery lock status, asynchronous |
| pwr_down_o | output | 1 | Channel power-down, 1 = powered down |
| pll_rst_o | output | 1 | Transmit PLL reset, 1 = in reset |
| tx_dig_rst_o | output | 1 | Transmit digital reset, 1 = in reset |
| rx_ana_rst_o | output | 1 | Receiver analog reset, 1 = in reset |
| rx_dig_rst_o | output | 1 | Receiver digital reset, 1 = in reset |
| seq_done_o | output | 1 | High while the channel is fully released and locked |

## Verification
The assertions check the ordering rules on every cycle. They check that power-down and the PLL reset move together, that each stage is released only after its earlier stage, and that no reset falls unless its qualifying status was valid on the cycle before. They also check that done never coexists with an asserted reset and that power-down never returns without a system reset. The exact release latencies cannot be seen from one cycle, so only the bench's scenarios show them. These are the power-down interval, the settling count after lock, the receiver delays, and the restart of the settling count when lock drops. The bench also shows which outputs a lock loss reasserts. It repeats the lock-loss recovery over several idle gaps.

// File: rtl/xrs_pkg.sv
package xrs_pkg;

  typedef enum logic [2:0] {
    ST_HOLD      = 3'd0,
    ST_WAIT_LOCK = 3'd1,
    ST_TX_SETTLE = 3'd2,
    ST_RX_BUSY   = 3'd3,
    ST_RX_ANA_DLY= 3'd4,
    ST_RX_CDR    = 3'd5,
    ST_RX_DIG_DLY= 3'd6,
    ST_DONE      = 3'd7
  } xrs_state_e;

  typedef struct packed {
    logic pwr_down;
    logic pll_rst;
    logic tx_rst;
    logic rx_ana_rst;
    logic rx_dig_rst;
    logic done;
  } xrs_ctl_t;

  // Control pattern produced in each sequencing state.
  function automatic xrs_ctl_t xrs_decode(input xrs_state_e st);
    xrs_ctl_t c;
    c = '{pwr_down: 1'b0, pll_rst: 1'b0, tx_rst: 1'b1,
          rx_ana_rst: 1'b1, rx_dig_rst: 1'b1, done: 1'b0};
    case (st)
      ST_HOLD: begin
        c.pwr_down = 1'b1;
        c.pll_rst  = 1'b1;
      end
      ST_RX_BUSY, ST_RX_ANA_DLY: c.tx_rst = 1'b0;
      ST_RX_CDR, ST_RX_DIG_DLY: begin
        c.tx_rst     = 1'b0;
        c.rx_ana_rst = 1'b0;
      end
      ST_DONE: begin
        c.tx_rst     = 1'b0;
        c.rx_ana_rst = 1'b0;
        c.rx_dig_rst = 1'b0;
        c.done       = 1'b1;
      end
      default: ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/xrs_sync.sv
module xrs_sync #(
  parameter int          WIDTH   = 3,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RST_VAL;
          else     chain[s] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RST_VAL;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_out = chain[STAGES-1];

endmodule

// File: rtl/xrs_timer.sv
module xrs_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          clr,
  input  logic [CW-1:0] limit,
  output logic          expire
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr)         cnt <= '0;
    else if (!expire) cnt <= cnt + CW'(1);
  end

  // Terminal value reached: the owner leaves its delay state on this edge.
  assign expire = (cnt == limit - CW'(1));

endmodule

// File: rtl/xrs_top.sv
module xrs_top
  import xrs_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int PD_CYCLES     = 100,
  parameter int TX_SETTLE     = 16,
  parameter int RX_ANA_CYCLES = 3,
  parameter int RX_DIG_CYCLES = 400
) (
  input  logic clk,
  input  logic rst,
  input  logic pll_lock_in,
  input  logic cal_busy_in,
  input  logic cdr_lock_in,
  output logic pwr_down_o,
  output logic pll_rst_o,
  output logic tx_dig_rst_o,
  output logic rx_ana_rst_o,
  output logic rx_dig_rst_o,
  output logic seq_done_o
);

  localparam int MAX_A  = (PD_CYCLES > TX_SETTLE) ? PD_CYCLES : TX_SETTLE;
  localparam int MAX_B  = (RX_ANA_CYCLES > RX_DIG_CYCLES) ? RX_ANA_CYCLES : RX_DIG_CYCLES;
  localparam int MAX_D  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW     = $clog2(MAX_D + 1);
  localparam logic [CW-1:0] LIM_PD  = CW'(PD_CYCLES);
  localparam logic [CW-1:0] LIM_TX  = CW'(TX_SETTLE);
  localparam logic [CW-1:0] LIM_ANA = CW'(RX_ANA_CYCLES);
  localparam logic [CW-1:0] LIM_DIG = CW'(RX_DIG_CYCLES);

  // Synchronized status: bit 2 pll lock, bit 1 calibration busy, bit 0 cdr lock
  logic [2:0] stat_s;
  logic       lock_s, busy_s, cdr_s;

  xrs_sync #(
    .WIDTH   (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b010)
  ) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  ({pll_lock_in, cal_busy_in, cdr_lock_in}),
    .q_out (stat_s)
  );

  assign lock_s = stat_s[2];
  assign busy_s = stat_s[1];
  assign cdr_s  = stat_s[0];

  xrs_state_e    state, state_n;
  logic [CW-1:0] lim;
  logic          wait_st, tmr_clr, expire;
  xrs_ctl_t      ctl_n;

  always_comb begin
    state_n = state;
    lim     = LIM_PD;
    wait_st = 1'b0;
    case (state)
      ST_HOLD: begin
        lim = LIM_PD;
        if (expire) state_n = ST_WAIT_LOCK;
      end
      ST_WAIT_LOCK: begin
        wait_st = 1'b1;
        if (lock_s) state_n = ST_TX_SETTLE;
      end
      ST_TX_SETTLE: begin
        lim = LIM_TX;
        if (!lock_s)     state_n = ST_WAIT_LOCK;
        else if (expire) state_n = ST_RX_BUSY;
      end
      ST_RX_BUSY: begin
        wait_st = 1'b1;
        if (!lock_s)      state_n = ST_WAIT_LOCK;
        else if (!busy_s) state_n = ST_RX_ANA_DLY;
      end
      ST_RX_ANA_DLY: begin
        lim = LIM_ANA;
        if (!lock_s)     state_n = ST_WAIT_LOCK;
        else if (busy_s) state_n = ST_RX_BUSY;
        else if (expire) state_n = ST_RX_CDR;
      end
      ST_RX_CDR: begin
        wait_st = 1'b1;
        if (!lock_s)    state_n = ST_WAIT_LOCK;
        else if (cdr_s) state_n = ST_RX_DIG_DLY;
      end
      ST_RX_DIG_DLY: begin
        lim = LIM_DIG;
        if (!lock_s)     state_n = ST_WAIT_LOCK;
        else if (!cdr_s) state_n = ST_RX_CDR;
        else if (expire) state_n = ST_DONE;
      end
      ST_DONE: begin
        wait_st = 1'b1;
        if (!lock_s)     state_n = ST_WAIT_LOCK;
        else if (!cdr_s) state_n = ST_RX_CDR;
      end
      default: state_n = ST_HOLD;
    endcase
  end

  assign tmr_clr = rst || wait_st || (state_n != state);

  xrs_timer #(.CW(CW)) u_timer (
    .clk    (clk),
    .clr    (tmr_clr),
    .limit  (lim),
    .expire (expire)
  );

  assign ctl_n = xrs_decode(state_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_HOLD;
      pwr_down_o   <= 1'b1;
      pll_rst_o    <= 1'b1;
      tx_dig_rst_o <= 1'b1;
      rx_ana_rst_o <= 1'b1;
      rx_dig_rst_o <= 1'b1;
      seq_done_o   <= 1'b0;
    end else begin
      state        <= state_n;
      pwr_down_o   <= ctl_n.pwr_down;
      pll_rst_o    <= ctl_n.pll_rst;
      tx_dig_rst_o <= ctl_n.tx_rst;
      rx_ana_rst_o <= ctl_n.rx_ana_rst;
      rx_dig_rst_o <= ctl_n.rx_dig_rst;
      seq_done_o   <= ctl_n.done;
    end
  end

  // R1
  rst_all_asserted_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pwr_down_o && pll_rst_o && tx_dig_rst_o && rx_ana_rst_o
                    && rx_dig_rst_o && !seq_done_o));

  // R2
  pd_pll_pair_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_down_o == pll_rst_o);

  // R4
  tx_release_locked_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_dig_rst_o) |-> $past(lock_s));

  // R5
  rx_ana_release_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_ana_rst_o) |-> !$past(busy_s));

  // R6
  rx_dig_release_locked_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_dig_rst_o) |-> $past(cdr_s));

  // R7
  done_clean_chk: assert property (@(posedge clk) disable iff (rst)
    seq_done_o |-> !(pwr_down_o || pll_rst_o || tx_dig_rst_o || rx_ana_rst_o || rx_dig_rst_o));

  // R7
  done_with_rx_dig_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(seq_done_o) |-> $fell(rx_dig_rst_o));

  // R8
  pd_no_return_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(pwr_down_o) |-> !pwr_down_o);

  // R10
  rx_ana_after_tx_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_ana_rst_o |-> !tx_dig_rst_o);

  // R10
  rx_dig_after_ana_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_dig_rst_o |-> !rx_ana_rst_o);

endmodule

// File: tb/xrs_top_bench.sv
module xrs_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int S   = 2;
  localparam int PD  = 5;
  localparam int TX  = 4;
  localparam int ANA = 3;
  localparam int DIG = 7;

  // obs bit positions
  localparam int B_PD = 5, B_PLL = 4, B_TX = 3, B_RXA = 2, B_RXD = 1, B_DONE = 0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lock = 1'b0, busy = 1'b1, cdr = 1'b0;
  logic pd, pllr, txr, rxa, rxd, done;
  logic [5:0] obs;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xrs_top #(
    .SYNC_STAGES(S), .PD_CYCLES(PD), .TX_SETTLE(TX),
    .RX_ANA_CYCLES(ANA), .RX_DIG_CYCLES(DIG)
  ) u_xrs_top (
    .clk(clk), .rst(rst), .pll_lock_in(lock), .cal_busy_in(busy), .cdr_lock_in(cdr),
    .pwr_down_o(pd), .pll_rst_o(pllr), .tx_dig_rst_o(txr),
    .rx_ana_rst_o(rxa), .rx_dig_rst_o(rxd), .seq_done_o(done)
  );

  assign obs = {pd, pllr, txr, rxa, rxd, done};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  // Counts rising edges from the next one until obs[idx]==tgt.
  task automatic meas(input int idx, input logic tgt, input int maxn, output int n);
    n = 0;
    while (n < maxn) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (obs[idx] == tgt) break;
    end
  endtask

  task automatic hold_check(input string req, input int idx, input logic val, input int n);
    int bad;
    bad = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (obs[idx] != val) bad++;
    end
    chk(req, bad, 0);
  endtask

  initial begin
    int n;
    step(1);
    // R1 reset state
    step(3);
    chk("R1 outputs in reset", int'(obs), 6'b111110);
    rst = 1'b0;
    // R2 power-down interval
    meas(B_PD, 1'b0, 50, n);
    chk("R2 pd release edge", n, PD);
    chk("R2 pll reset with pd", int'(pllr), 0);
    chk("R3 tx held after pd", int'(txr), 1);
    // R3 wait for lock
    hold_check("R3 tx held without lock", B_TX, 1'b1, 20);
    lock = 1'b1;
    meas(B_TX, 1'b0, 60, n);
    chk("R4 tx settle release", n, S + 1 + TX);
    chk("R5 rx_ana held", int'(rxa), 1);
    // R5 busy
    hold_check("R5 rx_ana held while busy", B_RXA, 1'b1, 10);
    busy = 1'b0;
    meas(B_RXA, 1'b0, 60, n);
    chk("R5 rx_ana release", n, S + 1 + ANA);
    // R6 cdr lock
    hold_check("R6 rx_dig held without cdr", B_RXD, 1'b1, 10);
    cdr = 1'b1;
    meas(B_RXD, 1'b0, 60, n);
    chk("R6 rx_dig release", n, S + 1 + DIG);
    chk("R7 done with rx_dig release", int'(done), 1);
    chk("R7 full release pattern", int'(obs), 6'b000001);
    // R9 cdr loss
    cdr = 1'b0;
    meas(B_RXD, 1'b1, 60, n);
    chk("R9 rx_dig reassert latency", n, S + 1);
    chk("R9 only rx_dig reasserted", int'(obs), 6'b000010);
    cdr = 1'b1;
    meas(B_RXD, 1'b0, 60, n);
    chk("R9 rx_dig re-release", n, S + 1 + DIG);
    chk("R7 done after re-release", int'(done), 1);
    // R8 pll lock loss, swept over idle gaps
    for (int g = 0; g < 4; g++) begin
      lock = 1'b0;
      meas(B_TX, 1'b1, 60, n);
      chk("R8 tx reassert latency", n, S + 1);
      chk("R8 reassert pattern", int'(obs), 6'b001110);
      step(g);
      lock = 1'b1;
      meas(B_TX, 1'b0, 60, n);
      chk("R8 tx re-release", n, S + 1 + TX);
      meas(B_RXA, 1'b0, 60, n);
      chk("R5 rx_ana with busy already low", n, ANA + 1);
      meas(B_RXD, 1'b0, 60, n);
      chk("R6 rx_dig with cdr already locked", n, DIG + 1);
      chk("R7 done after relock", int'(done), 1);
    end
    // R4 settle restart on lock glitch
    lock = 1'b0;
    meas(B_TX, 1'b1, 60, n);
    chk("R8 tx reassert before glitch", n, S + 1);
    lock = 1'b1;
    step(S + 2);
    lock = 1'b0;
    hold_check("R4 tx held across lock glitch", B_TX, 1'b1, S + 1 + TX + 4);
    lock = 1'b1;
    meas(B_TX, 1'b0, 60, n);
    chk("R4 settle restarted", n, S + 1 + TX);
    meas(B_RXD, 1'b0, 60, n);
    chk("R10 rx_dig after rx_ana", int'(rxa), 0);
    chk("R7 done at end", int'(done), 1);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule